// File: doc/BRIEF.md
# MAC Control Register and Descriptor-RAM Slave

This block is the software-visible control surface of an Ethernet MAC. It is a 32-bit memory-mapped slave holding twenty configuration and status words: operating mode, interrupt status and enable, three inter-packet gap values, frame length limits, collision settings, the transmit descriptor count, a control mode word, six management (MII) words, the 48-bit station address and two multicast hash words. A separate address window maps a word-addressed RAM that holds the buffer descriptors. The transmit and receive engines live outside this block. They raise interrupt status through set pulses, and they read the configuration from plain output pins.

The request side is a valid/ready channel. `req_ready` is always high, so every cycle in which `req_valid` is high accepts one access. The response side has no back-pressure. Each accepted access returns exactly one `rsp_valid` pulse in the next cycle, with read data or an error flag, and the requester must take it then. Writes take effect at the edge that accepts them.

Interrupt status bits are cleared when software writes a 1 to them. A write to the descriptor count register also reloads the receive engine's current descriptor index. The station address is packed least significant byte first across two registers.

Top module: `mac_regfile`

## Requirements
- R1: After reset, the word offsets read as follows: 0x00 mode 0x0000A000, 0x0C 0x12, 0x10 0x0C, 0x14 0x12, 0x18 frame length 0x003C0600, 0x1C 0x000F003F, 0x28 0x64, 0x20 descriptor count 0x80, and every other register 0. `rx_idx` resets to 0x80, `mode` to 0x0000A000 and `irq_status` to 0.
- R2: The frame length register at 0x18 drives `frame_min` from bits 31:16 and `frame_max` from bits 15:0, so the reset values are 60 and 1536.
- R3: A write to interrupt status (0x04) clears every status bit that is 1 in the written value and leaves the others unchanged. `irq_set` pulses set status bits. Status and mask (0x08) each keep IRQ_W bits and read 0 above them.
- R4: When an `irq_set` bit and a software clear of the same bit occur in the same cycle, the bit ends up set.
- R5: A write to the descriptor count register (0x20) keeps only the low 8 bits. The same value appears on `rx_idx` and is read back. `rx_idx_load` is high for exactly the one cycle after the accepting edge.
- R6: The station address register at 0x40 holds address bytes 3,2,1,0 from MSB to LSB. The register at 0x44 holds byte 5 in bits 15:8 and byte 4 in bits 7:0, and reads 0 in bits 31:16. `station_addr` carries byte i in bits 8i+7:8i.
- R7: Aligned accesses at offsets 0x400 to 0x5FC read or write descriptor RAM word (offset-0x400)/4.
- R8: An access with `req_addr[1:0]` not 00 is rejected. The response has `rsp_err`=1 and `rsp_rdata`=0, and a rejected write changes no register and no RAM word.
- R9: Aligned accesses outside both regions (0x50 to 0x3FC, and 0x600 and above) respond with `rsp_err`=1 and `rsp_rdata`=0, and writes to them have no effect.
- R10: Every accepted request yields exactly one `rsp_valid` cycle, in the cycle after acceptance. Write responses carry `rsp_rdata`=0 and `rsp_err`=0 when the access is mapped.
- R11: Full-width registers such as the hash words (0x48, 0x4C) store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_err | output | 1 | Access was misaligned or unmapped |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| irq_set | input | IRQ_W | Per-bit interrupt status set pulses from the engines |
| irq_status | output | IRQ_W | Current interrupt status |
| irq_mask | output | IRQ_W | Current interrupt enables |
| mode | output | 32 | Mode register |
| frame_min | output | 16 | Minimum frame length |
| frame_max | output | 16 | Maximum frame length |
| station_addr | output | 48 | Station address, byte i at bits 8i+7:8i |
| rx_idx | output | 8 | Receive descriptor index reload value |
| rx_idx_load | output | 1 | Pulse: receive engine must reload its index |

## Verification
Every response, both register and RAM reads, is due exactly one cycle after the rising edge that accepts the request. Register side effects appear on the output pins after that same edge, and `rx_idx_load` is high only during that following cycle. The bench drives requests at the falling edge and lets a scoreboard monitor compare each `rsp_valid` at the next falling edge against the item queued by the driver. It samples side-effect pins at the falling edge right after acceptance and once more a cycle later to confirm pulses end.

// File: rtl/mac_regs_pkg.sv
package mac_regs_pkg;
  localparam int NREG  = 20;
  localparam int IDX_W = $clog2(NREG);

  localparam int RI_MODE       = 0;
  localparam int RI_IRQ_STAT   = 1;
  localparam int RI_IRQ_MASK   = 2;
  localparam int RI_GAP_B2B    = 3;
  localparam int RI_GAP_R1     = 4;
  localparam int RI_GAP_R2     = 5;
  localparam int RI_FRAME_LEN  = 6;
  localparam int RI_COLL_CFG   = 7;
  localparam int RI_TXDESC_CNT = 8;
  localparam int RI_CTRL_MODE  = 9;
  localparam int RI_MGMT_MODE  = 10;
  localparam int RI_MGMT_CMD   = 11;
  localparam int RI_MGMT_ADDR  = 12;
  localparam int RI_MGMT_WDATA = 13;
  localparam int RI_MGMT_RDATA = 14;
  localparam int RI_MGMT_STAT  = 15;
  localparam int RI_STA0       = 16;
  localparam int RI_STA1       = 17;
  localparam int RI_HASH0      = 18;
  localparam int RI_HASH1      = 19;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_RAM  = 2'd2
  } target_e;

  function automatic logic [31:0] reg_reset(int i);
    case (i)
      RI_MODE:       return 32'h0000_A000;
      RI_GAP_B2B:    return 32'h0000_0012;
      RI_GAP_R1:     return 32'h0000_000C;
      RI_GAP_R2:     return 32'h0000_0012;
      RI_FRAME_LEN:  return 32'h003C_0600;
      RI_COLL_CFG:   return 32'h000F_003F;
      RI_MGMT_MODE:  return 32'h0000_0064;
      RI_TXDESC_CNT: return 32'h0000_0080;
      default:       return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] reg_wmask(int i, int irq_w);
    logic [31:0] m;
    m = '0;
    case (i)
      RI_IRQ_STAT, RI_IRQ_MASK: begin
        for (int k = 0; k < irq_w; k++) m[k] = 1'b1;
      end
      RI_TXDESC_CNT: m = 32'h0000_00FF;
      RI_STA1:       m = 32'h0000_FFFF;
      default:       m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mac_bus_decode.sv
module mac_bus_decode
  import mac_regs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h400,
  parameter int BD_WORDS = 128,
  localparam int RAM_AW  = $clog2(BD_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output target_e           tgt,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [RAM_AW-1:0] ram_idx
);
  localparam int WIN_END = WIN_BASE + 4 * BD_WORDS;
  localparam int REG_END = 4 * NREG;

  logic [31:0] off;
  logic [31:0] win_off;
  logic        aligned;

  assign off     = 32'(addr);
  assign win_off = off - 32'(WIN_BASE);
  assign aligned = (addr[1:0] == 2'b00);
  assign reg_idx = addr[IDX_W+1:2];
  assign ram_idx = win_off[RAM_AW+1:2];

  always_comb begin
    tgt = TGT_NONE;
    if (aligned) begin
      if (off < 32'(REG_END))
        tgt = TGT_REG;
      else if (off >= 32'(WIN_BASE) && off < 32'(WIN_END))
        tgt = TGT_RAM;
    end
  end
endmodule

// File: rtl/mac_csr_bank.sv
module mac_csr_bank
  import mac_regs_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [IRQ_W-1:0] irq_set,
  output logic [31:0]      rdata,
  output logic [IRQ_W-1:0] irq_status,
  output logic [IRQ_W-1:0] irq_mask,
  output logic [31:0]      mode,
  output logic [15:0]      frame_min,
  output logic [15:0]      frame_max,
  output logic [47:0]      station_addr,
  output logic [7:0]       rx_idx,
  output logic             rx_idx_load
);
  localparam logic [31:0] TXCNT_RST = reg_reset(RI_TXDESC_CNT);

  logic [31:0] regs [NREG];
  logic [31:0] set_ext;

  assign set_ext = 32'(irq_set);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [31:0] RST  = reg_reset(g);
    localparam logic [31:0] MASK = reg_wmask(g, IRQ_W);
    logic        hit;
    logic [31:0] q;
    assign hit     = wr_en && (32'(idx) == 32'(g));
    assign regs[g] = q;
    if (g == RI_IRQ_STAT) begin : g_w1c
      always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= ((q & ~(hit ? wdata : 32'h0)) | set_ext) & MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST;
        else if (hit) q <= wdata & MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_idx      <= TXCNT_RST[7:0];
      rx_idx_load <= 1'b0;
    end else begin
      rx_idx_load <= wr_en && (32'(idx) == 32'(RI_TXDESC_CNT));
      if (wr_en && (32'(idx) == 32'(RI_TXDESC_CNT)))
        rx_idx <= wdata[7:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(idx) < 32'(NREG)) rdata = regs[idx];
  end

  assign irq_status   = regs[RI_IRQ_STAT][IRQ_W-1:0];
  assign irq_mask     = regs[RI_IRQ_MASK][IRQ_W-1:0];
  assign mode         = regs[RI_MODE];
  assign frame_min    = regs[RI_FRAME_LEN][31:16];
  assign frame_max    = regs[RI_FRAME_LEN][15:0];
  assign station_addr = {regs[RI_STA1][15:0], regs[RI_STA0]};

  // R4: a set pulse always lands, even against a same-cycle clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((irq_status & $past(irq_set)) == $past(irq_set)));

  // R3: with no set pulse, every written 1 clears its status bit
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(idx) == 32'(RI_IRQ_STAT) && !(|irq_set))
      |=> ((32'(irq_status) & $past(wdata)) == 32'h0));

  // R5: count write reloads the receive index with its low byte
  assert_rx_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(idx) == 32'(RI_TXDESC_CNT))
      |=> (rx_idx_load && rx_idx == $past(wdata[7:0])));
endmodule

// File: rtl/mac_desc_ram.sv
module mac_desc_ram #(
  parameter int WORDS = 128,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/mac_regfile.sv
module mac_regfile
  import mac_regs_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h400,
  parameter int BD_WORDS = 128,
  parameter int IRQ_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  input  logic [IRQ_W-1:0]  irq_set,
  output logic [IRQ_W-1:0]  irq_status,
  output logic [IRQ_W-1:0]  irq_mask,
  output logic [31:0]       mode,
  output logic [15:0]       frame_min,
  output logic [15:0]       frame_max,
  output logic [47:0]       station_addr,
  output logic [7:0]        rx_idx,
  output logic              rx_idx_load
);
  localparam int RAM_AW = $clog2(BD_WORDS);

  target_e           tgt;
  logic [IDX_W-1:0]  reg_idx;
  logic [RAM_AW-1:0] ram_idx;
  logic [31:0]       csr_rdata;
  logic [31:0]       ram_rdata;
  logic              reg_wr, ram_wr, ram_rd;
  logic              rsp_rd_q, rsp_ram_q;
  logic [31:0]       reg_q;

  assign req_ready = 1'b1;
  assign reg_wr = req_valid && req_write && (tgt == TGT_REG);
  assign ram_wr = req_valid && req_write && (tgt == TGT_RAM);
  assign ram_rd = req_valid && !req_write && (tgt == TGT_RAM);

  mac_bus_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .BD_WORDS(BD_WORDS)
  ) u_dec (
    .addr(req_addr), .tgt(tgt), .reg_idx(reg_idx), .ram_idx(ram_idx)
  );

  mac_csr_bank #(.IRQ_W(IRQ_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx),
    .wdata(req_wdata), .irq_set(irq_set), .rdata(csr_rdata),
    .irq_status(irq_status), .irq_mask(irq_mask), .mode(mode),
    .frame_min(frame_min), .frame_max(frame_max),
    .station_addr(station_addr), .rx_idx(rx_idx),
    .rx_idx_load(rx_idx_load)
  );

  mac_desc_ram #(.WORDS(BD_WORDS)) u_ram (
    .clk(clk), .we(ram_wr), .re(ram_rd), .idx(ram_idx),
    .wdata(req_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rd_q  <= 1'b0;
      rsp_ram_q <= 1'b0;
      reg_q     <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (tgt == TGT_NONE);
      rsp_rd_q  <= req_valid && !req_write;
      rsp_ram_q <= (tgt == TGT_RAM);
      reg_q     <= csr_rdata;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (rsp_valid && rsp_rd_q && !rsp_err)
      rsp_rdata = rsp_ram_q ? ram_rdata : reg_q;
  end

  // R10: one response per accepted request, in the next cycle
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8: misaligned access is flagged and leaves configuration untouched
  assert_misaligned_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'h0));
  assert_misaligned_noeffect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[1:0] != 2'b00)
      |=> ($stable(mode) && $stable(station_addr) && $stable(rx_idx)
           && $stable(frame_min) && $stable(frame_max)));
endmodule

// File: tb/sim_mac_regfile.sv
module sim_mac_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [IW-1:0] irq_set = '0;
  logic [IW-1:0] irq_status, irq_mask;
  logic [31:0]   mode;
  logic [15:0]   frame_min, frame_max;
  logic [47:0]   station_addr;
  logic [7:0]    rx_idx;
  logic          rx_idx_load;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_data_q [$];
  logic        exp_err_q  [$];
  string       exp_tag_q  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_regfile u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .irq_set(irq_set), .irq_status(irq_status), .irq_mask(irq_mask),
    .mode(mode), .frame_min(frame_min), .frame_max(frame_max),
    .station_addr(station_addr), .rx_idx(rx_idx), .rx_idx_load(rx_idx_load)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one request, expected response queued for the monitor
  task automatic access(bit wr, logic [AW-1:0] a, logic [31:0] d,
                        logic [31:0] exp_d, bit exp_e, string tag,
                        logic [IW-1:0] set = '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    irq_set = set;
    exp_data_q.push_back(exp_d);
    exp_err_q.push_back(exp_e);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; irq_set = '0;
  endtask

  // monitor: compares each response against the queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_data_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected response actual=1 expected=0");
      end else begin
        string t;
        logic [31:0] ed;
        logic ee;
        t = exp_tag_q.pop_front();
        ed = exp_data_q.pop_front();
        ee = exp_err_q.pop_front();
        chk({t, " rdata"}, 64'(rsp_rdata), 64'(ed));
        chk({t, " err"}, 64'(rsp_err), 64'(ee));
      end
    end
  end

  function automatic logic [31:0] reset_of(int i);
    case (i)
      0: return 32'h0000A000;  3: return 32'h12;  4: return 32'h0C;
      5: return 32'h12;        6: return 32'h003C0600;
      7: return 32'h000F003F;  8: return 32'h80;  10: return 32'h64;
      default: return 32'h0;
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on pins and in every register
    chk("R1 mode pin", 64'(mode), 64'h0000A000);
    chk("R1 rx_idx", 64'(rx_idx), 64'h80);
    chk("R1 irq_status", 64'(irq_status), 64'h0);
    chk("R10 ready", 64'(req_ready), 64'h1);
    chk("R10 idle rsp", 64'(rsp_valid), 64'h0);
    chk("R2 min reset", 64'(frame_min), 64'd60);
    chk("R2 max reset", 64'(frame_max), 64'd1536);
    for (int i = 0; i < 20; i++)
      access(0, AW'(4 * i), 0, reset_of(i), 0, $sformatf("R1 reg%0d", i));

    // R2: frame length split
    access(1, 12'h018, 32'h0040_0800, 0, 0, "R2 write");
    chk("R2 min", 64'(frame_min), 64'h40);
    chk("R2 max", 64'(frame_max), 64'h800);

    // R5: descriptor count write and index reload
    access(1, 12'h020, 32'h1234_56A5, 0, 0, "R5 write");
    chk("R5 load pulse", 64'(rx_idx_load), 64'h1);
    chk("R5 rx_idx", 64'(rx_idx), 64'hA5);
    @(negedge clk);
    chk("R5 load ends", 64'(rx_idx_load), 64'h0);
    access(0, 12'h020, 0, 32'hA5, 0, "R5 readback");

    // R6: station address packing
    access(1, 12'h040, 32'h4433_2211, 0, 0, "R6 w0");
    access(1, 12'h044, 32'hFFFF_6655, 0, 0, "R6 w1");
    chk("R6 station", 64'(station_addr), 64'h6655_4433_2211);
    access(0, 12'h044, 0, 32'h6655, 0, "R6 r1");
    access(0, 12'h040, 0, 32'h4433_2211, 0, "R6 r0");

    // R3: set pulses and write-one-to-clear
    @(negedge clk); irq_set = 8'hFF;
    @(negedge clk); irq_set = 8'h00;
    chk("R3 set", 64'(irq_status), 64'hFF);
    access(1, 12'h004, 32'h0000_000F, 0, 0, "R3 clear");
    chk("R3 after clear", 64'(irq_status), 64'hF0);
    access(1, 12'h004, 32'h0, 0, 0, "R3 zero write");
    access(0, 12'h004, 0, 32'hF0, 0, "R3 unchanged");
    access(1, 12'h008, 32'hFFFF_FFFF, 0, 0, "R3 mask write");
    access(0, 12'h008, 0, 32'hFF, 0, "R3 mask width");
    chk("R3 mask pin", 64'(irq_mask), 64'hFF);

    // R4: set beats same-cycle clear (0xF0 &~0x30 | 0x10 = 0xD0)
    access(1, 12'h004, 32'h30, 0, 0, "R4 write", 8'h10);
    chk("R4 priority", 64'(irq_status), 64'hD0);
    access(0, 12'h004, 0, 32'hD0, 0, "R4 readback");

    // R11: full-width hash registers
    access(1, 12'h048, 32'hDEAD_BEEF, 0, 0, "R11 w");
    access(0, 12'h048, 0, 32'hDEAD_BEEF, 0, "R11 r");

    // R7: descriptor window
    access(1, 12'h400, 32'hA0A0_0001, 0, 0, "R7 w first");
    access(1, 12'h5FC, 32'hB0B0_0002, 0, 0, "R7 w last");
    access(1, 12'h404, 32'hC0C0_0003, 0, 0, "R7 w second");
    access(0, 12'h400, 0, 32'hA0A0_0001, 0, "R7 r first");
    access(0, 12'h5FC, 0, 32'hB0B0_0002, 0, "R7 r last");
    access(0, 12'h404, 0, 32'hC0C0_0003, 0, "R7 r second");

    // R8: misaligned accesses
    access(1, 12'h002, 32'hFFFF_FFFF, 0, 1, "R8 mis write reg");
    chk("R8 mode kept", 64'(mode), 64'h0000A000);
    access(1, 12'h021, 32'h0000_0011, 0, 1, "R8 mis write cnt");
    chk("R8 rx_idx kept", 64'(rx_idx), 64'hA5);
    access(1, 12'h406, 32'h1111_1111, 0, 1, "R8 mis write ram");
    access(0, 12'h404, 0, 32'hC0C0_0003, 0, "R8 ram kept");
    access(0, 12'h401, 0, 0, 1, "R8 mis read");

    // R9: unmapped aligned accesses
    access(0, 12'h050, 0, 0, 1, "R9 gap read");
    access(0, 12'h600, 0, 0, 1, "R9 past window");
    access(1, 12'h3FC, 32'h5555_5555, 0, 1, "R9 gap write");
    access(0, 12'h000, 0, 32'h0000A000, 0, "R9 mode kept");

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 64'(exp_data_q.size()), 64'h0);
    finish_run();
  end
endmodule